// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver with General Call

This block is a write-only slave on a two-wire serial bus with open-drain lines. It watches the clock and data lines, detects START and STOP, and shifts in the first byte after each START as a 7-bit address plus a direction bit. It takes part in the transfer only when three things are true: the byte is a write, the address is either its own address or the all-zero general call address, and the host allows acknowledgement. A configuration byte holds the 7-bit own address in bits 7:1. Bit 0 of that byte lets the slave answer the general call. A separate acknowledge-enable input lets the host cut the slave off from the bus at run time. The slave still tracks bus activity while it is cut off.

The block reports each event to the host in two ways: an 8-bit status code and an interrupt flag. After an address or data event it holds SCL low until the host clears the flag, so the master waits while the host reads the byte. The FSM states are S_IDLE, S_ADDR, S_ADDR_ACK, S_DATA, S_DATA_ACK and S_SKIP. The transitions are as follows:
- START from any state goes to S_ADDR.
- STOP goes to S_IDLE.
- In S_ADDR, the end of the eighth bit goes to S_ADDR_ACK if the address is accepted, and to S_SKIP if it is not.
- S_ADDR_ACK goes to S_DATA when the acknowledge clock falls.
- In S_DATA, the end of the eighth bit goes to S_DATA_ACK.
- S_DATA_ACK goes back to S_DATA after an ACK, or to S_SKIP after a NACK.
- Deasserting the enable input forces S_IDLE.

Top module: `twi_slave_rx`

## Requirements
- R1: After reset the interrupt flag is 0, the status reads F8h, and neither SDA nor SCL is driven low.
- R2: A write to the own address (address byte = own address in bits 7:1, bit 0 = 0) is acknowledged by pulling SDA low during the ninth clock. The flag is then set with status 60h.
- R3: With general call enabled (configuration bit 0 = 1), an address byte of 00h is acknowledged and gives status 70h. With it disabled, 00h gets no acknowledge and sets no flag.
- R4: A non-matching address, or a matching address with the direction bit at 1, is not acknowledged and sets no flag. Data bytes after it get no acknowledge and set no flag until the next START.
- R5: While acknowledge-enable is 0, the own address is not acknowledged. After it is set again, the own address is recognised from the next START on.
- R6: A data byte received while addressed with acknowledge-enable at 1 is acknowledged. The byte, taken MSB first, appears on rx_data, and the status is 80h for the own address or 90h for the general call.
- R7: If acknowledge-enable is 0 when a data byte ends, that byte gets a NACK (SDA left high) with status 88h (own address) or 98h (general call). The slave then drops out of the transfer until the next START.
- R8: A STOP or repeated START while addressed sets the flag with status A0h without stretching SCL. A repeated START is then followed by normal address handling.
- R9: After an address or data event the slave holds SCL low while the flag is set. Clearing the flag releases SCL.
- R10: With the enable input at 0 the slave drives nothing, raises no flag and acknowledges nothing.
- R11: Once set, the flag stays set until irq_clear is pulsed (or the enable input drops).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low (acknowledge) |
| cfg_own_addr | input | 8 | Bits 7:1 own address, bit 0 general call enable |
| cfg_enable | input | 1 | Block enable |
| cfg_ack_en | input | 1 | Allow acknowledgement of address and data |
| irq_clear | input | 1 | One-cycle pulse that clears the flag |
| irq_flag | output | 1 | Event flag for the host |
| status | output | 8 | Code of the last event |
| rx_data | output | 8 | Last received data byte |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- **Address 00h with general call disabled.** A comparator that treats 00h as always valid would acknowledge it.
- **Matching address with the read bit set.** A design that ignores the direction bit would enter receive mode.
- **Acknowledge-enable dropped in the middle of a transfer.** The slave must NACK the next byte and then ignore the bytes that follow. A design that stays addressed would keep raising the flag.
- **Flag cleared while the master is already trying to raise SCL.** SCL must stay low until the clear and rise right after it. A design that does not stretch would let the master run ahead; one that never releases would hang the run.
- **STOP and repeated START after a NACK, and while the block is disabled.** These must set no flag. A design that keeps stale addressing would report A0h anyway.

// File: rtl/twi_rx_pkg.sv
package twi_rx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_ACK,
        S_DATA,
        S_DATA_ACK,
        S_SKIP
    } twi_state_t;

    localparam logic [7:0] CODE_OWN_ADDR  = 8'h60;
    localparam logic [7:0] CODE_GC_ADDR   = 8'h70;
    localparam logic [7:0] CODE_OWN_ACK   = 8'h80;
    localparam logic [7:0] CODE_OWN_NACK  = 8'h88;
    localparam logic [7:0] CODE_GC_ACK    = 8'h90;
    localparam logic [7:0] CODE_GC_NACK   = 8'h98;
    localparam logic [7:0] CODE_END       = 8'hA0;
    localparam logic [7:0] CODE_NONE      = 8'hF8;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= scl_i;
                    sda_chain <= sda_i;
                end
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_chain <= '1;
                    sda_chain <= '1;
                end else begin
                    scl_chain <= {scl_chain[STAGES-2:0], scl_i};
                    sda_chain <= {sda_chain[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s     = scl_chain[STAGES-1];
    assign sda_s     = sda_chain[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/twi_byte_shift.sv
module twi_byte_shift #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] value,
    output logic             full
);

    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
            count <= '0;
        end else if (clear) begin
            value <= '0;
            count <= '0;
        end else if (shift_en) begin
            value <= {value[WIDTH-2:0], bit_in};
            count <= count + 1'b1;
        end
    end

    assign full = (count == CW'(WIDTH));

endmodule

// File: rtl/twi_slave_rx.sv
module twi_slave_rx
    import twi_rx_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W:0]   cfg_own_addr,
    input  logic              cfg_enable,
    input  logic              cfg_ack_en,
    input  logic              irq_clear,
    output logic              irq_flag,
    output logic [7:0]        status,
    output logic [ADDR_W:0]   rx_data
);

    localparam int BYTE_W = ADDR_W + 1;

    twi_state_t state_q;
    twi_state_t state_d;

    logic scl_sync;
    logic sda_sync;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    logic [BYTE_W-1:0] sh_value;
    logic              sh_full;
    logic              sh_clear;
    logic              sh_en;
    logic              in_shift;

    logic addressed;
    logic byte_end;
    logic own_hit;
    logic gc_hit;
    logic addr_ok;
    logic gc_mode;
    logic nack_q;
    logic stretch_q;

    logic       set_flag;
    logic       set_stretch;
    logic [7:0] next_status;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    assign in_shift = (state_q == S_ADDR) || (state_q == S_DATA);
    assign sh_clear = !in_shift || start_det;
    assign sh_en    = scl_rise && in_shift && !sh_full;

    twi_byte_shift #(.WIDTH(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .shift_en (sh_en),
        .bit_in   (sda_sync),
        .value    (sh_value),
        .full     (sh_full)
    );

    assign addressed = (state_q == S_ADDR_ACK) || (state_q == S_DATA) ||
                       (state_q == S_DATA_ACK);
    assign byte_end  = sh_full && scl_fall;
    assign own_hit   = (sh_value[BYTE_W-1:1] == cfg_own_addr[ADDR_W:1]);
    assign gc_hit    = (sh_value[BYTE_W-1:1] == '0) && cfg_own_addr[0];
    assign addr_ok   = cfg_ack_en && !sh_value[0] && (own_hit || gc_hit);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!cfg_enable) begin
            state_d = S_IDLE;
        end else if (start_det) begin
            state_d = S_ADDR;
        end else if (stop_det) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:     state_d = S_IDLE;
                S_ADDR:     if (byte_end) state_d = addr_ok ? S_ADDR_ACK : S_SKIP;
                S_ADDR_ACK: if (scl_fall) state_d = S_DATA;
                S_DATA:     if (byte_end) state_d = S_DATA_ACK;
                S_DATA_ACK: if (scl_fall) state_d = nack_q ? S_SKIP : S_DATA;
                S_SKIP:     state_d = S_SKIP;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // Event decode for the host interface
    always_comb begin
        set_flag    = 1'b0;
        set_stretch = 1'b0;
        next_status = CODE_NONE;
        if (cfg_enable) begin
            if (addressed && (start_det || stop_det)) begin
                set_flag    = 1'b1;
                next_status = CODE_END;
            end else if (!start_det && !stop_det && scl_fall) begin
                if (state_q == S_ADDR_ACK) begin
                    set_flag    = 1'b1;
                    set_stretch = 1'b1;
                    next_status = gc_mode ? CODE_GC_ADDR : CODE_OWN_ADDR;
                end else if (state_q == S_DATA_ACK) begin
                    set_flag    = 1'b1;
                    set_stretch = 1'b1;
                    unique case ({gc_mode, nack_q})
                        2'b00:   next_status = CODE_OWN_ACK;
                        2'b01:   next_status = CODE_OWN_NACK;
                        2'b10:   next_status = CODE_GC_ACK;
                        default: next_status = CODE_GC_NACK;
                    endcase
                end
            end
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            irq_flag  <= 1'b0;
            stretch_q <= 1'b0;
            status    <= CODE_NONE;
            rx_data   <= '0;
            gc_mode   <= 1'b0;
            nack_q    <= 1'b0;
        end else if (!cfg_enable) begin
            sda_oe    <= 1'b0;
            irq_flag  <= 1'b0;
            stretch_q <= 1'b0;
        end else begin
            if (set_flag) begin
                irq_flag  <= 1'b1;
                stretch_q <= set_stretch;
                status    <= next_status;
            end else if (irq_clear) begin
                irq_flag  <= 1'b0;
                stretch_q <= 1'b0;
            end

            if (start_det || stop_det) begin
                sda_oe <= 1'b0;
            end else if (state_q == S_ADDR && byte_end) begin
                sda_oe  <= addr_ok;
                gc_mode <= !own_hit;
            end else if (state_q == S_DATA && byte_end) begin
                sda_oe  <= cfg_ack_en;
                nack_q  <= !cfg_ack_en;
                rx_data <= sh_value;
            end else if ((state_q == S_ADDR_ACK || state_q == S_DATA_ACK) && scl_fall) begin
                sda_oe <= 1'b0;
            end
        end
    end

    assign scl_oe = irq_flag && stretch_q;

endmodule

// File: rtl/twi_slave_rx_chk.sv
module twi_slave_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic       irq_clear,
    input logic       irq_flag,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] status,
    input logic       scl_sync
);

    AST_STRETCH_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> irq_flag); // R9

    AST_FLAG_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_flag) |-> ($past(irq_clear) || !$past(cfg_enable))); // R11

    AST_STATUS_ON_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> (status inside {8'h60, 8'h70, 8'h80, 8'h88,
                                            8'h90, 8'h98, 8'hA0})); // R2

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> (!sda_oe && !scl_oe && !irq_flag)); // R10

    AST_ACK_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_sync); // R6

    AST_END_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && status == 8'hA0) |-> !scl_oe); // R8

endmodule

bind twi_slave_rx twi_slave_rx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .irq_clear  (irq_clear),
    .irq_flag   (irq_flag),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .status     (status),
    .scl_sync   (scl_sync)
);

// File: tb/sim_twi_slave_rx.sv
module sim_twi_slave_rx;

    localparam int H = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       m_scl;
    logic       m_sda;
    logic       scl_line;
    logic       sda_line;
    logic       scl_oe;
    logic       sda_oe;
    logic [7:0] cfg_own_addr;
    logic       cfg_enable;
    logic       cfg_ack_en;
    logic       irq_clear;
    logic       irq_flag;
    logic [7:0] status;
    logic [7:0] rx_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    assign scl_line = m_scl & ~scl_oe;
    assign sda_line = m_sda & ~sda_oe;

    twi_slave_rx u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_line),
        .sda_i        (sda_line),
        .scl_oe       (scl_oe),
        .sda_oe       (sda_oe),
        .cfg_own_addr (cfg_own_addr),
        .cfg_enable   (cfg_enable),
        .cfg_ack_en   (cfg_ack_en),
        .irq_clear    (irq_clear),
        .irq_flag     (irq_flag),
        .status       (status),
        .rx_data      (rx_data)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_code(input bit gc);
        return gc ? 8'h70 : 8'h60;
    endfunction

    function automatic logic [7:0] data_code(input bit gc, input bit nack);
        return 8'h80 + (gc ? 8'h10 : 8'h00) + (nack ? 8'h08 : 8'h00);
    endfunction

    task automatic clear_flag();
        irq_clear = 1'b1;
        wt(1);
        irq_clear = 1'b0;
        wt(1);
    endtask

    task automatic raise_scl();
        m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        wt(H);
    endtask

    task automatic send_start();
        m_sda = 1'b1;
        wt(H);
        raise_scl();
        m_sda = 1'b0;
        wt(H);
        m_scl = 1'b0;
        wt(H + 4);
    endtask

    task automatic send_stop();
        m_sda = 1'b0;
        wt(H);
        raise_scl();
        m_sda = 1'b1;
        wt(H + 4);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit stretch_chk, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i];
            wt(H);
            if (i == 7 && stretch_chk) begin
                m_scl = 1'b1;
                wt(20);
                chk1("R9 SCL held while flag set", scl_line, 1'b0);
                clear_flag();
                wt(6);
                chk1("R9 SCL released after clear", scl_line, 1'b1);
            end
            raise_scl();
            m_scl = 1'b0;
            wt(H);
        end
        m_sda = 1'b1;
        wt(H);
        raise_scl();
        acked = !sda_line;
        m_scl = 1'b0;
        wt(H + 4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit ack;
        bit ack_en;
        bit addressed;
        bit gc;
        logic [6:0] own;
        logic [6:0] a;
        logic [7:0] d;
        bit gc_en;
        bit rw;
        bit hit_own;
        bit hit_gc;
        bit exp_acc;
        string req;

        void'($urandom(32'd4242));
        rst_n        = 1'b0;
        m_scl        = 1'b1;
        m_sda        = 1'b1;
        cfg_own_addr = {7'h35, 1'b0};
        cfg_enable   = 1'b1;
        cfg_ack_en   = 1'b1;
        irq_clear    = 1'b0;
        wt(5);
        rst_n = 1'b1;
        wt(5);

        // R1 reset state
        chk1("R1 flag after reset", irq_flag, 1'b0);
        chk8("R1 status after reset", status, 8'hF8);
        chk1("R1 sda idle", sda_oe, 1'b0);
        chk1("R1 scl idle", scl_oe, 1'b0);

        // R2 own address, R9 stretching, R6 data
        send_start();
        send_byte({7'h35, 1'b0}, 1'b0, ack);
        chk1("R2 own addr ack", ack, 1'b1);
        chk1("R2 flag", irq_flag, 1'b1);
        chk8("R2 status", status, 8'h60);
        chk1("R9 stretch active", scl_oe, 1'b1);
        send_byte(8'hA5, 1'b1, ack);
        chk1("R6 data ack", ack, 1'b1);
        chk8("R6 status", status, 8'h80);
        chk8("R6 rx_data", rx_data, 8'hA5);
        wt(30);
        chk1("R11 flag held without clear", irq_flag, 1'b1);
        clear_flag();
        chk1("R11 flag cleared", irq_flag, 1'b0);

        // R8 repeated start while addressed, then general call R3
        cfg_own_addr = {7'h35, 1'b1};
        send_start();
        chk1("R8 flag on repeated start", irq_flag, 1'b1);
        chk8("R8 status A0", status, 8'hA0);
        chk1("R8 no stretch", scl_oe, 1'b0);
        clear_flag();
        send_byte(8'h00, 1'b0, ack);
        chk1("R3 gc ack", ack, 1'b1);
        chk8("R3 gc status", status, 8'h70);
        clear_flag();
        send_byte(8'h3C, 1'b0, ack);
        chk8("R6 gc data status", status, 8'h90);
        chk8("R6 gc rx_data", rx_data, 8'h3C);
        clear_flag();
        // R7 ack enable dropped mid-transfer
        cfg_ack_en = 1'b0;
        send_byte(8'h77, 1'b0, ack);
        chk1("R7 nack", ack, 1'b0);
        chk8("R7 gc nack status", status, 8'h98);
        clear_flag();
        cfg_ack_en = 1'b1;
        send_byte(8'h11, 1'b0, ack);
        chk1("R7 byte after nack ignored", ack, 1'b0);
        chk1("R7 no flag after nack", irq_flag, 1'b0);
        send_stop();
        chk1("R7 stop after nack gives no flag", irq_flag, 1'b0);

        // R3 general call disabled
        cfg_own_addr = {7'h35, 1'b0};
        send_start();
        send_byte(8'h00, 1'b0, ack);
        chk1("R3 gc disabled no ack", ack, 1'b0);
        chk1("R3 gc disabled no flag", irq_flag, 1'b0);
        send_stop();

        // R5 isolation and resume
        cfg_ack_en = 1'b0;
        send_start();
        send_byte({7'h35, 1'b0}, 1'b0, ack);
        chk1("R5 isolated no ack", ack, 1'b0);
        chk1("R5 isolated no flag", irq_flag, 1'b0);
        cfg_ack_en = 1'b1;
        send_start();
        chk1("R5 repeated start unaddressed no flag", irq_flag, 1'b0);
        send_byte({7'h35, 1'b0}, 1'b0, ack);
        chk1("R5 resumed ack", ack, 1'b1);
        chk8("R5 resumed status", status, 8'h60);
        clear_flag();
        send_stop();
        chk8("R8 stop status", status, 8'hA0);
        clear_flag();

        // R4 read direction
        send_start();
        send_byte({7'h35, 1'b1}, 1'b0, ack);
        chk1("R4 read no ack", ack, 1'b0);
        send_byte(8'h12, 1'b0, ack);
        chk1("R4 data ignored", ack, 1'b0);
        chk1("R4 no flag", irq_flag, 1'b0);
        send_stop();

        // R10 disabled
        cfg_enable = 1'b0;
        send_start();
        send_byte({7'h35, 1'b0}, 1'b0, ack);
        chk1("R10 disabled no ack", ack, 1'b0);
        chk1("R10 disabled no flag", irq_flag, 1'b0);
        send_stop();
        cfg_enable = 1'b1;
        wt(10);

        // Random transactions
        for (int t = 0; t < 36; t++) begin
            own          = 7'($urandom_range(1, 127));
            gc_en        = 1'($urandom_range(0, 1));
            cfg_own_addr = {own, gc_en};
            ack_en       = ($urandom_range(0, 9) < 8);
            cfg_ack_en   = ack_en;
            case ($urandom_range(0, 9)) inside
                [0:3]:   a = own;
                [4:6]:   a = 7'h00;
                default: begin
                    a = 7'($urandom_range(1, 127));
                    while (a == own) a = 7'($urandom_range(1, 127));
                end
            endcase
            rw      = ($urandom_range(0, 3) == 0);
            hit_own = (a == own);
            hit_gc  = (a == 7'h00) && gc_en;
            exp_acc = ack_en && !rw && (hit_own || hit_gc);
            gc      = !hit_own;
            if (rw)           req = "R4 read addr";
            else if (!ack_en) req = "R5 isolated addr";
            else if (hit_own) req = "R2 own addr";
            else if (a == 0)  req = "R3 gc addr";
            else              req = "R4 other addr";
            send_start();
            send_byte({a, rw}, 1'b0, ack);
            chk1(req, ack, exp_acc);
            chk1(req, irq_flag, exp_acc);
            if (exp_acc) begin
                chk8(req, status, addr_code(gc));
                clear_flag();
            end
            addressed = exp_acc;
            for (int b = 0; b < $urandom_range(1, 3); b++) begin
                if ($urandom_range(0, 3) == 0) ack_en = !ack_en;
                cfg_ack_en = ack_en;
                d = 8'($urandom);
                send_byte(d, 1'b0, ack);
                if (addressed) begin
                    chk1(ack_en ? "R6 rand data ack" : "R7 rand data nack", ack, ack_en);
                    chk1("R6 rand data flag", irq_flag, 1'b1);
                    chk8(ack_en ? "R6 rand status" : "R7 rand status", status, data_code(gc, !ack_en));
                    chk8("R6 rand rx_data", rx_data, d);
                    clear_flag();
                    if (!ack_en) addressed = 1'b0;
                end else begin
                    chk1("R4 rand unaddressed no ack", ack, 1'b0);
                    chk1("R4 rand unaddressed no flag", irq_flag, 1'b0);
                end
            end
            send_stop();
            chk1("R8 rand stop flag", irq_flag, addressed);
            if (addressed) begin
                chk8("R8 rand stop status", status, 8'hA0);
                chk1("R8 rand stop no stretch", scl_oe, 1'b0);
                clear_flag();
            end
            wt(10);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule